// File: doc/BRIEF.md
# Prioritized interrupt vector tracker

This block keeps the pending and active state for a 256-entry interrupt vector space. Each vector has three marks: requested, in service, and level-triggered. Interrupt sources post a vector through a set port, with a flag that marks it level or edge. The block reports the highest-numbered requested vector. It also raises a deliverable flag when that vector's priority class is above the processor priority value supplied from outside.

The consumer accepts the reported vector through the acknowledge port. This moves the vector from requested to in service. Later, an end-of-interrupt pulse retires the highest-numbered vector in service. If that vector was level-triggered, the block emits a one-cycle notification carrying the vector number, so that the interrupt source can re-sample its line.

One vector, chosen at run time as the timer vector, gets special treatment. Repeat postings that arrive while it is still requested are counted rather than dropped. Each acknowledge while the count is non-zero re-posts the vector and lowers the count by one.

Top module: `irq_vec_tracker`

## Requirements
- R1: After reset nothing is requested, in service or level-marked. `top_valid_o`, `deliver_o`, `set_dup_o` and `eoi_notify_o` are low, and the overflow count is zero.
- R2: A set of vector v makes v requested from the next cycle on. `top_valid_o` is high whenever any vector is requested, and `top_vec_o` then equals the highest-numbered requested vector. With nothing requested, `top_valid_o` is low.
- R3: `set_dup_o` is high in the same cycle as `set_valid_i` exactly when the presented vector is already requested.
- R4: `deliver_o` is high only when a vector is requested and (`top_vec_o` AND 0xF0) is strictly greater than `ppr_i`. An equal or lower value holds the vector back.
- R5: While `glob_en_i` is low, `deliver_o` is low. The stored marks are untouched, so delivery resumes when the enable returns.
- R6: An acknowledge of vector v clears its request and sets its in-service mark, from the next cycle on. If a set of the same vector arrives in the same cycle, the vector stays requested.
- R7: A set with `set_level_i` high also marks the vector level-triggered. When an end-of-interrupt retires a level-marked vector, the level mark is cleared. `eoi_notify_o` is then high for the following cycle only, and `eoi_vec_o` equals that vector during that cycle.
- R8: An end-of-interrupt retires the highest-numbered vector in service. Retiring an edge vector gives no notification. With nothing in service, an end-of-interrupt changes nothing.
- R9: A set of the vector equal to `timer_vec_i` while it is already requested raises an 8-bit overflow count, which stops at 255. An acknowledge of the timer vector while the count is non-zero leaves it requested and lowers the count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| glob_en_i | input | 1 | Global enable for the deliverable flag |
| ppr_i | input | 8 | Processor priority value |
| timer_vec_i | input | 8 | Vector that receives overflow counting |
| set_valid_i | input | 1 | Post a vector request |
| set_vec_i | input | 8 | Vector to post |
| set_level_i | input | 1 | Posted vector is level-triggered |
| set_dup_o | output | 1 | Posted vector was already requested |
| ack_valid_i | input | 1 | Acknowledge a vector |
| ack_vec_i | input | 8 | Vector being acknowledged |
| eoi_valid_i | input | 1 | End-of-interrupt |
| top_valid_o | output | 1 | Some vector is requested |
| top_vec_o | output | 8 | Highest requested vector |
| deliver_o | output | 1 | Highest requested vector outranks the processor priority |
| eoi_notify_o | output | 1 | Level-triggered vector retired (one cycle) |
| eoi_vec_o | output | 8 | Vector of the retired level-triggered request |

## Verification
Directed postings put pending vectors on both sides of a 32-bit word boundary and in separate words. This shows whether the scan picks the right word and the right bit inside it. A priority sweep sets the processor priority just below, equal to and above the pending class, which separates the strict comparison from a non-strict one. Mixed edge and level vectors are retired in order, showing both that the highest in-service vector is chosen and that only level vectors notify. A long burst of timer repeats pushes the overflow count into saturation and then drains it one acknowledge at a time, exposing both a wrap and an off-by-one. A random phase then mixes simultaneous set, acknowledge and end-of-interrupt traffic, so that the same-cycle ordering rules are compared every cycle.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_INC  = 2'd1,
      CNT_DEC  = 2'd2
   } cnt_op_e;

   function automatic cnt_op_e cnt_op_pick(input logic inc, input logic dec);
      if (inc && !dec) return CNT_INC;
      if (dec && !inc) return CNT_DEC;
      return CNT_HOLD;
   endfunction

endpackage

// File: rtl/ivt_bitmap.sv
module ivt_bitmap #(
   parameter int unsigned NUM_VEC = 256,
   parameter int unsigned WORD_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set_mask_i,
   input  logic [NUM_VEC-1:0] clr_mask_i,
   output logic [NUM_VEC-1:0] bits_o
);
   localparam int unsigned WORDS = NUM_VEC / WORD_W;

   if (NUM_VEC % WORD_W != 0) begin : g_bad_split
      $error("ivt_bitmap: NUM_VEC must be a multiple of WORD_W");
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) word_q <= '0;
         else        word_q <= (word_q & ~clr_mask_i[w*WORD_W +: WORD_W])
                               | set_mask_i[w*WORD_W +: WORD_W];
      end
      assign bits_o[w*WORD_W +: WORD_W] = word_q;
   end

   // R2: every bit asked to be set is set one cycle later
   p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_mask_i) |=> ((bits_o & $past(set_mask_i)) == $past(set_mask_i)));

endmodule

// File: rtl/ivt_prio_scan.sv
module ivt_prio_scan #(
   parameter int unsigned NUM_VEC = 256,
   parameter int unsigned WORD_W  = 32
) (
   input  logic [NUM_VEC-1:0]         bits_i,
   output logic                       any_o,
   output logic [$clog2(NUM_VEC)-1:0] idx_o
);
   localparam int unsigned WORDS  = NUM_VEC / WORD_W;
   localparam int unsigned WIDX_W = $clog2(WORD_W);
   localparam int unsigned WSEL_W = $clog2(WORDS);

   if (WORDS < 2) begin : g_bad_words
      $error("ivt_prio_scan: at least two words are required");
   end

   logic [WORDS-1:0]             word_any;
   logic [WORDS-1:0][WIDX_W-1:0] word_msb;
   logic [WSEL_W-1:0]            sel;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [WORD_W-1:0] slice;
      logic [WIDX_W-1:0] msb;
      assign slice = bits_i[w*WORD_W +: WORD_W];
      always_comb begin
         msb = '0;
         for (int b = 0; b < WORD_W; b++)
            if (slice[b]) msb = WIDX_W'(b);
      end
      assign word_any[w] = |slice;
      assign word_msb[w] = msb;
   end

   // the highest non-empty word wins, equivalent to a top-down search
   always_comb begin
      sel = '0;
      for (int w = 0; w < WORDS; w++)
         if (word_any[w]) sel = WSEL_W'(w);
   end

   assign any_o = |word_any;
   assign idx_o = {sel, word_msb[sel]};

endmodule

// File: rtl/ivt_sat_counter.sv
module ivt_sat_counter
   import ivt_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cnt_op_e          op_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q <= '0;
         else begin
            case (op_i)
               CNT_INC: if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
               CNT_DEC: if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
               default: ;
            endcase
         end
      end

      // R9: a full count never wraps to zero
      p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_o == CNT_MAX && op_i == CNT_INC) |=> (cnt_o == CNT_MAX));
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q <= '0;
         else begin
            case (op_i)
               CNT_INC: cnt_q <= cnt_q + 1'b1;
               CNT_DEC: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/irq_vec_tracker.sv
module irq_vec_tracker
   import ivt_pkg::*;
#(
   parameter int unsigned NUM_VEC = 256,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned SUB_W   = 4,
   parameter int unsigned OVF_W   = 8,
   localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glob_en_i,
   input  logic [VEC_W-1:0] ppr_i,
   input  logic [VEC_W-1:0] timer_vec_i,
   input  logic             set_valid_i,
   input  logic [VEC_W-1:0] set_vec_i,
   input  logic             set_level_i,
   output logic             set_dup_o,
   input  logic             ack_valid_i,
   input  logic [VEC_W-1:0] ack_vec_i,
   input  logic             eoi_valid_i,
   output logic             top_valid_o,
   output logic [VEC_W-1:0] top_vec_o,
   output logic             deliver_o,
   output logic             eoi_notify_o,
   output logic [VEC_W-1:0] eoi_vec_o
);
   localparam logic [VEC_W-1:0]   CLASS_MASK = ~VEC_W'((1 << SUB_W) - 1);
   localparam logic [NUM_VEC-1:0] ONE_HOT    = NUM_VEC'(1);

   if (SUB_W >= VEC_W) begin : g_bad_class
      $error("irq_vec_tracker: SUB_W must leave at least one class bit");
   end
   if ((1 << VEC_W) != NUM_VEC) begin : g_bad_size
      $error("irq_vec_tracker: NUM_VEC must be a power of two");
   end

   logic [NUM_VEC-1:0] req_bits, isr_bits, trg_bits;
   logic [NUM_VEC-1:0] set_m, ack_m, eoi_m, reload_m;
   logic               isr_any;
   logic [VEC_W-1:0]   isr_top;
   logic [OVF_W-1:0]   ovf_cnt;
   logic               reload, ovf_inc;
   logic               ntf_q;
   logic [VEC_W-1:0]   ntf_vec_q;

   // one-hot strobes for the three ports
   assign set_m    = set_valid_i ? (ONE_HOT << set_vec_i) : '0;
   assign ack_m    = ack_valid_i ? (ONE_HOT << ack_vec_i) : '0;
   assign eoi_m    = (eoi_valid_i && isr_any) ? (ONE_HOT << isr_top) : '0;
   assign reload   = ack_valid_i && (ack_vec_i == timer_vec_i) && (ovf_cnt != '0);
   assign reload_m = reload ? ack_m : '0;

   assign set_dup_o = set_valid_i && req_bits[set_vec_i];
   assign ovf_inc   = set_dup_o && (set_vec_i == timer_vec_i);

   // requested: acknowledge clears, new postings and timer re-posts win
   ivt_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_req (
      .clk(clk), .rst_n(rst_n),
      .set_mask_i(set_m | reload_m), .clr_mask_i(ack_m), .bits_o(req_bits));

   // in service: end-of-interrupt clears, acknowledge sets
   ivt_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr (
      .clk(clk), .rst_n(rst_n),
      .set_mask_i(ack_m), .clr_mask_i(eoi_m), .bits_o(isr_bits));

   // level marks: retirement clears, a level posting sets
   ivt_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_trg (
      .clk(clk), .rst_n(rst_n),
      .set_mask_i(set_level_i ? set_m : '0), .clr_mask_i(eoi_m & trg_bits),
      .bits_o(trg_bits));

   ivt_prio_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_req_scan (
      .bits_i(req_bits), .any_o(top_valid_o), .idx_o(top_vec_o));

   ivt_prio_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr_scan (
      .bits_i(isr_bits), .any_o(isr_any), .idx_o(isr_top));

   ivt_sat_counter #(.CNT_W(OVF_W), .SATURATE(1'b1)) u_ovf (
      .clk(clk), .rst_n(rst_n), .op_i(cnt_op_pick(ovf_inc, reload)), .cnt_o(ovf_cnt));

   assign deliver_o = glob_en_i && top_valid_o && ((top_vec_o & CLASS_MASK) > ppr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ntf_q     <= 1'b0;
         ntf_vec_q <= '0;
      end else begin
         ntf_q <= |(eoi_m & trg_bits);
         if (|eoi_m) ntf_vec_q <= isr_top;
      end
   end

   assign eoi_notify_o = ntf_q;
   assign eoi_vec_o    = ntf_vec_q;

   // R2: the reported vector is really requested
   p_top_is_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
      top_valid_o |-> req_bits[top_vec_o]);

   // R3: a duplicate posting implies the scan sees a pending vector
   p_dup_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_dup_o |-> top_valid_o);

   // R6: a plain acknowledge removes the request
   p_ack_removes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid_i && (ack_vec_i != timer_vec_i) &&
       !(set_valid_i && (set_vec_i == ack_vec_i)))
      |=> !req_bits[$past(ack_vec_i)]);

   // R7: a notification follows an end-of-interrupt
   p_notify_after_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_notify_o |-> $past(eoi_valid_i));

   // R8: end-of-interrupt with nothing in service stays quiet
   p_eoi_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid_i && !isr_any) |=> !eoi_notify_o);

   // R9: counted timer repeats keep the vector requested after acknowledge
   p_repost_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid_i && (ack_vec_i == timer_vec_i) && (ovf_cnt != '0))
      |=> req_bits[$past(ack_vec_i)]);

endmodule

// File: tb/irq_vec_tracker_tb_top.sv
module irq_vec_tracker_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       glob_en = 1'b1;
   logic [7:0] ppr = '0;
   logic [7:0] timer_vec = 8'hFF;
   logic       set_valid = 1'b0;
   logic [7:0] set_vec = '0;
   logic       set_level = 1'b0;
   logic       ack_valid = 1'b0;
   logic [7:0] ack_vec = '0;
   logic       eoi_valid = 1'b0;
   logic       set_dup_o, top_valid_o, deliver_o, eoi_notify_o;
   logic [7:0] top_vec_o, eoi_vec_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vec_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .glob_en_i(glob_en), .ppr_i(ppr),
      .timer_vec_i(timer_vec), .set_valid_i(set_valid), .set_vec_i(set_vec),
      .set_level_i(set_level), .set_dup_o(set_dup_o), .ack_valid_i(ack_valid),
      .ack_vec_i(ack_vec), .eoi_valid_i(eoi_valid), .top_valid_o(top_valid_o),
      .top_vec_o(top_vec_o), .deliver_o(deliver_o), .eoi_notify_o(eoi_notify_o),
      .eoi_vec_o(eoi_vec_o));

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   bit req_m [NV];
   bit isr_m [NV];
   bit trg_m [NV];
   int ovf_m     = 0;
   bit ntf_m     = 1'b0;
   int ntf_vec_m = 0;

   function automatic int hi_of(input bit a [NV]);
      int h = -1;
      for (int i = 0; i < NV; i++) if (a[i]) h = i;
      return h;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(string scn);
      int h = hi_of(req_m);
      chk({scn, "/R2"}, "top_valid", int'(top_valid_o), int'(h >= 0));
      if (h >= 0) chk({scn, "/R2"}, "top_vec", int'(top_vec_o), h);
      chk({scn, "/R4"}, "deliver", int'(deliver_o),
          int'(glob_en && h >= 0 && ((h & 'hF0) > int'(ppr))));
      chk({scn, "/R3"}, "set_dup", int'(set_dup_o), int'(set_valid && req_m[set_vec]));
      chk({scn, "/R7"}, "eoi_notify", int'(eoi_notify_o), int'(ntf_m));
      if (ntf_m) chk({scn, "/R7"}, "eoi_vec", int'(eoi_vec_o), ntf_vec_m);
   endtask

   task automatic model_step();
      int he     = hi_of(isr_m);
      bit dup    = set_valid && req_m[set_vec];
      bit reload = ack_valid && (ack_vec == timer_vec) && (ovf_m > 0);
      bit inc    = dup && (set_vec == timer_vec);
      bit ntf_n  = 1'b0;
      if (eoi_valid && he >= 0) begin
         isr_m[he] = 1'b0;
         if (trg_m[he]) begin
            trg_m[he] = 1'b0;
            ntf_n = 1'b1;
         end
         ntf_vec_m = he;
      end
      if (ack_valid) begin
         isr_m[ack_vec] = 1'b1;
         req_m[ack_vec] = reload;
      end
      if (set_valid) begin
         req_m[set_vec] = 1'b1;
         if (set_level) trg_m[set_vec] = 1'b1;
      end
      ovf_m = ovf_m + int'(inc) - int'(reload);
      if (ovf_m > 255) ovf_m = 255;
      ntf_m = ntf_n;
   endtask

   task automatic cyc(string scn);
      #1 compare(scn);
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic idle();
      set_valid = 1'b0; ack_valid = 1'b0; eoi_valid = 1'b0; set_level = 1'b0;
   endtask

   task automatic post(int v, bit lvl, string scn);
      set_valid = 1'b1; set_vec = 8'(v); set_level = lvl;
      cyc(scn);
      idle();
   endtask

   task automatic ack(int v, string scn);
      ack_valid = 1'b1; ack_vec = 8'(v);
      cyc(scn);
      idle();
   endtask

   task automatic eoi(string scn);
      eoi_valid = 1'b1;
      cyc(scn);
      idle();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NV; i++) begin
         req_m[i] = 1'b0; isr_m[i] = 1'b0; trg_m[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: empty state after reset
      chk("R1", "top_valid", int'(top_valid_o), 0);
      chk("R1", "deliver", int'(deliver_o), 0);
      chk("R1", "eoi_notify", int'(eoi_notify_o), 0);
      chk("R1", "set_dup", int'(set_dup_o), 0);
      cyc("R1");

      // R2: vectors across separate words and a word boundary
      post(8'h45, 0, "R2");
      chk("R2", "top_vec_single", int'(top_vec_o), 8'h45);
      post(8'h1F, 0, "R2");
      post(8'h20, 0, "R2");
      post(8'h21, 0, "R2");
      post(8'hC3, 0, "R2");
      chk("R2", "top_vec_high", int'(top_vec_o), 8'hC3);

      // R4: strict class comparison around 0xC0
      ppr = 8'hC0; cyc("R4");
      chk("R4", "equal_class_held", int'(deliver_o), 0);
      ppr = 8'hBF; cyc("R4");
      chk("R4", "lower_ppr_delivers", int'(deliver_o), 1);
      ppr = 8'hC5; cyc("R4");

      // R5: global enable gate keeps the state
      ppr = 8'h00; glob_en = 1'b0; cyc("R5");
      chk("R5", "deliver_gated", int'(deliver_o), 0);
      glob_en = 1'b1; cyc("R5");
      chk("R5", "deliver_back", int'(deliver_o), 1);

      // R3: duplicate posting
      set_valid = 1'b1; set_vec = 8'hC3; #1;
      chk("R3", "dup_flag", int'(set_dup_o), 1);
      cyc("R3"); idle();

      // R6: acknowledge moves to the next pending vector
      ack(8'hC3, "R6");
      chk("R6", "next_top", int'(top_vec_o), 8'h45);
      // R6: same-cycle set and acknowledge keep the vector pending
      set_valid = 1'b1; set_vec = 8'h21; ack_valid = 1'b1; ack_vec = 8'h21;
      cyc("R6"); idle();

      // R7/R8: level vector below an edge vector in service
      post(8'h50, 1, "R7");
      ack(8'h50, "R7");
      eoi("R8");              // retires 0xC3, an edge vector
      chk("R8", "edge_no_notify", int'(eoi_notify_o), 0);
      eoi("R7");              // retires 0x50, a level vector
      chk("R7", "notify", int'(eoi_notify_o), 1);
      chk("R7", "notify_vec", int'(eoi_vec_o), 8'h50);
      cyc("R7");
      chk("R7", "notify_one_cycle", int'(eoi_notify_o), 0);
      // drain everything in service, then an idle end-of-interrupt
      for (int k = 0; k < 4; k++) eoi("R8");
      eoi("R8");
      chk("R8", "empty_eoi_quiet", int'(eoi_notify_o), 0);

      // R9: timer overflow count saturates and drains
      timer_vec = 8'hE0;
      post(8'hE0, 0, "R9");
      for (int k = 0; k < 300; k++) post(8'hE0, 0, "R9");
      for (int k = 0; k < 255; k++) ack(8'hE0, "R9");
      chk("R9", "still_pending", int'(top_valid_o && top_vec_o == 8'hE0), 1);
      ack(8'hE0, "R9");
      chk("R9", "drained", int'(top_valid_o && top_vec_o == 8'hE0), 0);
      for (int k = 0; k < 8; k++) eoi("R8");

      // mixed traffic compared against the model every cycle
      timer_vec = 8'h9A;
      for (int k = 0; k < 4000; k++) begin
         int h = hi_of(req_m);
         glob_en   = ($urandom % 16) != 0;
         ppr       = 8'($urandom);
         set_valid = ($urandom % 2) == 0;
         set_vec   = (($urandom % 4) == 0) ? timer_vec : 8'($urandom);
         set_level = ($urandom % 3) == 0;
         ack_valid = ($urandom % 3) == 0;
         ack_vec   = (h >= 0 && ($urandom % 10) < 7) ? 8'(h) : 8'($urandom);
         eoi_valid = ($urandom % 4) == 0;
         cyc("R9mix");
      end
      idle();
      cyc("R2");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule